// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block is the transmit half of a remote-control infrared link. Software or a sequencer upstream hands it a stream of pulse commands. Each command says whether the pulse is a mark (light on) or a space (light off) and how long it lasts, counted in units of a programmable base period. The block queues the commands and plays them out back to back on a single drive pin. Marks are chopped by a carrier whose frequency and duty cycle are set by configuration, and spaces hold the pin low. Because the pulse list is free-form, any private remote-control coding can be sent by building the right list of marks and spaces.

The carrier period is twelve sub-ticks, and each sub-tick lasts a configurable number of clocks. A two-bit code selects how many sub-ticks of each period are high, which gives duty cycles of one half, five twelfths, one third or one quarter. The carrier phase starts again at the first clock of every mark command, so each burst opens with a high stretch. When the last queued command ends, the block raises a one-cycle completion pulse and leaves the pin low.

Top module: `irtx_modulator`

## Requirements
- R1: During and just after reset, `ir_out`, `busy` and `done` are 0 and `cmd_ready` is 1.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. It holds `cmd_mark` (1 = mark, 0 = space) and a 16-bit `cmd_units` count N. If the queue was empty and the block idle, playback of that command starts two cycles after that edge. It lasts N × `cfg_unit_clks` clocks. Queued commands follow one another with no gap.
- R3: Throughout a space command, `ir_out` is 0.
- R4: Throughout a mark command, `ir_out` follows a carrier whose period is 12 × `cfg_sub_clks` clocks. In clock j of the command (counting from 0), the sub-tick index is (j / `cfg_sub_clks`) mod 12, and `ir_out` is 1 when that index is below H. H is 6, 5, 4 or 3 for `cfg_duty` codes 0, 1, 2 and 3.
- R5: The carrier phase restarts at the first clock of every mark command, including a mark that directly follows another mark.
- R6: A command with `cmd_units` equal to 0 is dropped. It is not queued, it produces no output and it does not raise `busy`.
- R7: `done` is a one-cycle pulse in the clock after the last clock of the final queued command. In that cycle `ir_out` and `busy` are 0.
- R8: `busy` is 1 from the cycle after a command is taken until the queue is empty and playback has finished. It falls only together with `done`.
- R9: `cmd_ready` is 0 while the queue holds `FIFO_DEPTH` entries. A command offered then is not taken.
- R10: `ir_out` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_unit_clks | input | UNIT_W | Clocks per base period t (at least 1, stable while busy) |
| cfg_sub_clks | input | SUB_W | Clocks per carrier sub-tick (at least 1, stable while busy) |
| cfg_duty | input | 2 | Carrier duty code: 0 = 6/12, 1 = 5/12, 2 = 4/12, 3 = 3/12 |
| cmd_valid | input | 1 | Pulse command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_mark | input | 1 | 1 = mark, 0 = space |
| cmd_units | input | 16 | Pulse length in base periods; 0 is dropped |
| ir_out | output | 1 | Modulated infrared drive |
| busy | output | 1 | Commands queued or playing |
| done | output | 1 | One-cycle pulse after the final command ends |

## Verification
Every cycle, the assertions check the relationships among the status signals: the pin is low when idle, `done` is a single-cycle pulse with the pin and `busy` low, `busy` only falls together with `done`, and a full queue implies `busy`. The exact carrier waveform cannot be checked that way. This covers the sub-tick count for each duty code, the restart of the phase at each mark, the seamless joins between commands and the dropped zero-length commands. Only the bench's sweeps show these. They run over duty codes, sub-tick lengths and unit lengths, and every output clock is compared with a value computed from the requirements. The bench's directed runs also show the exact position of `done` after a long queue and the back-pressure of a full queue.

// File: rtl/irtx_pkg.sv
// Shared definitions for the infrared carrier modulator.
// Assumes a twelve-sub-tick carrier period and 16-bit pulse counts.
package irtx_pkg;

    localparam int IRTX_SUBTICKS = 12;
    localparam int IRTX_CNT_W    = 16;

    typedef struct packed {
        logic                  mark;
        logic [IRTX_CNT_W-1:0] units;
    } irtx_cmd_t;

    localparam int IRTX_CMD_W = $bits(irtx_cmd_t);

    // Number of high sub-ticks per carrier period for a duty code.
    function automatic logic [3:0] irtx_high_ticks(input logic [1:0] code);
        logic [3:0] h;
        case (code)
            2'd0:    h = 4'd6;
            2'd1:    h = 4'd5;
            2'd2:    h = 4'd4;
            default: h = 4'd3;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/irtx_cmd_fifo.sv
// Small synchronous queue for pulse commands.
// Assumes DEPTH is a power of two, at least 2. Push when full and pop when
// empty are ignored. Data is shown at the head without a read latency.
module irtx_cmd_fifo #(
    parameter int WIDTH = 17,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/irtx_carrier.sv
// Carrier generator: twelve sub-ticks per period, each sub_clks clocks long.
// Output is high for the first H sub-ticks, H taken from the duty code.
// Assumes sub_clks >= 1. A restart puts the phase back to its start.
module irtx_carrier
    import irtx_pkg::*;
#(
    parameter int SUB_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SUB_W-1:0] sub_clks,
    input  logic [1:0]       duty,
    output logic             carrier_hi
);
    localparam logic [3:0] LAST_TICK = 4'(IRTX_SUBTICKS - 1);

    logic [SUB_W-1:0] sub_cnt;
    logic [3:0]       phase;
    logic             tick_end;

    assign tick_end   = (sub_cnt == sub_clks - 1'b1);
    assign carrier_hi = (phase < irtx_high_ticks(duty));

    // Advance the sub-tick counter and the phase within the period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub_cnt <= '0;
            phase   <= '0;
        end else if (run) begin
            if (tick_end) begin
                sub_cnt <= '0;
                phase   <= (phase == LAST_TICK) ? 4'd0 : phase + 4'd1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irtx_pulse_seq.sv
// Pulse sequencer: loads commands from the queue head and times each one
// as units x unit_clks clocks. Chains to the next command with no gap
// and flags completion when the queue runs dry.
// Assumes unit_clks >= 1 and that queued counts are nonzero.
module irtx_pulse_seq
    import irtx_pkg::*;
#(
    parameter int UNIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irtx_cmd_t         head,
    input  logic              head_valid,
    input  logic [UNIT_W-1:0] unit_clks,
    output logic              pop,
    output logic              active,
    output logic              mark,
    output logic              done
);
    localparam logic [IRTX_CNT_W-1:0] ONE_UNIT = IRTX_CNT_W'(1);

    logic [UNIT_W-1:0]     unit_cnt;
    logic [IRTX_CNT_W-1:0] units_left;
    logic                  unit_end, finishing;

    assign unit_end  = (unit_cnt == unit_clks - 1'b1);
    assign finishing = active && unit_end && (units_left == ONE_UNIT);
    assign pop       = head_valid && (!active || finishing);

    // Load, count down and retire pulse commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            mark       <= 1'b0;
            unit_cnt   <= '0;
            units_left <= '0;
        end else if (pop) begin
            active     <= 1'b1;
            mark       <= head.mark;
            unit_cnt   <= '0;
            units_left <= head.units;
        end else if (finishing) begin
            active <= 1'b0;
            mark   <= 1'b0;
        end else if (active) begin
            if (unit_end) begin
                unit_cnt   <= '0;
                units_left <= units_left - 1'b1;
            end else begin
                unit_cnt <= unit_cnt + 1'b1;
            end
        end
    end

    // One-cycle completion flag when the last command ends with nothing queued.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finishing && !pop;
    end
endmodule

// File: rtl/irtx_modulator.sv
// Infrared carrier modulator top: queues mark/space commands, times them
// in base periods and gates marks with the carrier.
// Assumes configuration inputs are held stable while busy is high.
module irtx_modulator
    import irtx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int UNIT_W     = 16,
    parameter int SUB_W      = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [UNIT_W-1:0]     cfg_unit_clks,
    input  logic [SUB_W-1:0]      cfg_sub_clks,
    input  logic [1:0]            cfg_duty,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_mark,
    input  logic [IRTX_CNT_W-1:0] cmd_units,
    output logic                  ir_out,
    output logic                  busy,
    output logic                  done
);
    irtx_cmd_t in_cmd, head;
    logic      push, pop, q_empty, q_full;
    logic      seq_active, seq_mark, carrier_hi;

    assign in_cmd.mark  = cmd_mark;
    assign in_cmd.units = cmd_units;
    assign cmd_ready    = !q_full;
    assign push         = cmd_valid && cmd_ready && (cmd_units != '0);

    irtx_cmd_fifo #(
        .WIDTH (IRTX_CMD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (in_cmd),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (q_empty),
        .full    (q_full)
    );

    irtx_pulse_seq #(
        .UNIT_W (UNIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .head_valid (!q_empty),
        .unit_clks  (cfg_unit_clks),
        .pop        (pop),
        .active     (seq_active),
        .mark       (seq_mark),
        .done       (done)
    );

    irtx_carrier #(
        .SUB_W (SUB_W)
    ) u_car (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (pop),
        .run        (seq_active),
        .sub_clks   (cfg_sub_clks),
        .duty       (cfg_duty),
        .carrier_hi (carrier_hi)
    );

    assign ir_out = seq_active && seq_mark && carrier_hi;
    assign busy   = seq_active || !q_empty;
endmodule

// File: rtl/irtx_modulator_chk.sv
// Property checker for the infrared carrier modulator, bound to the top.
// Assumes synchronous active-low reset.
module irtx_modulator_chk (
    input logic clk,
    input logic rst_n,
    input logic ir_out,
    input logic busy,
    input logic done,
    input logic cmd_ready
);
    // Pin stays low while idle.
    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ir_out);

    // Completion lasts one cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion coincides with an idle, low pin.
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !ir_out));

    // Busy falls only together with completion.
    assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // A full queue means work is pending.
    assert_full_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> busy);
endmodule

bind irtx_modulator irtx_modulator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_out    (ir_out),
    .busy      (busy),
    .done      (done),
    .cmd_ready (cmd_ready)
);

// File: tb/sim_irtx_modulator.sv
module sim_irtx_modulator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_unit_clks = 16'd1;
    logic [11:0] cfg_sub_clks = 12'd1;
    logic [1:0]  cfg_duty = 2'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_mark = 1'b0;
    logic [15:0] cmd_units = 16'd0;
    logic        ir_out, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int q_mark [8];
    int q_units[8];
    int q_n;

    always #2 clk = ~clk;

    irtx_modulator u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_unit_clks (cfg_unit_clks),
        .cfg_sub_clks  (cfg_sub_clks),
        .cfg_duty      (cfg_duty),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_mark      (cmd_mark),
        .cmd_units     (cmd_units),
        .ir_out        (ir_out),
        .busy          (busy),
        .done          (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Play the queued list (first entry nonzero) and compare every output clock.
    task automatic play();
        fork
            begin
                for (int i = 0; i < q_n; i++) begin
                    @(negedge clk);
                    cmd_valid = 1'b1;
                    cmd_mark  = q_mark[i][0];
                    cmd_units = 16'(q_units[i]);
                    @(posedge clk);
                end
                @(negedge clk);
                cmd_valid = 1'b0;
            end
            begin
                @(negedge clk);
                @(posedge clk);
                @(negedge clk);
                check(busy == 1'b1, "R8 busy after accept", busy, 1);
                @(posedge clk);
                for (int k = 0; k < q_n; k++) begin
                    int len;
                    len = q_units[k] * int'(cfg_unit_clks);
                    for (int j = 0; j < len; j++) begin
                        int ph, exp;
                        ph  = (j / int'(cfg_sub_clks)) % 12;
                        exp = (q_mark[k] != 0 && ph < (6 - int'(cfg_duty))) ? 1 : 0;
                        @(negedge clk);
                        // R2 R3 R4 R5 R6 waveform; R8 busy throughout
                        check(ir_out == exp[0], q_mark[k] != 0 ? "R4 R5 mark carrier" : "R3 space low",
                              ir_out, exp);
                        check(busy && !done, "R8 busy during playback", {busy, done}, 2);
                        @(posedge clk);
                    end
                end
                @(negedge clk);
                check(done && !busy && !ir_out, "R7 done after final unit", {done, busy, ir_out}, 4);
                @(posedge clk);
                @(negedge clk);
                check(!done, "R7 done one cycle", done, 0);
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ir_out && !busy && !done && cmd_ready, "R1 reset state",
              {ir_out, busy, done, cmd_ready}, 1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!ir_out && !busy && !done && cmd_ready, "R1 after reset",
              {ir_out, busy, done, cmd_ready}, 1);

        // Sweep duty codes, sub-tick and unit lengths; back-to-back marks test R5.
        for (int d = 0; d < 4; d++) begin
            for (int s = 1; s <= 3; s++) begin
                for (int u = 1; u <= 2; u++) begin
                    cfg_duty      = 2'(d);
                    cfg_sub_clks  = 12'(s);
                    cfg_unit_clks = 16'(u);
                    q_n = 4;
                    q_mark[0] = 1; q_units[0] = 20;
                    q_mark[1] = 0; q_units[1] = 3;
                    q_mark[2] = 1; q_units[2] = 9;
                    q_mark[3] = 1; q_units[3] = 13;
                    play();
                end
            end
        end

        // R6: zero-length command inside a list is dropped with no gap.
        cfg_duty = 2'd2; cfg_sub_clks = 12'd2; cfg_unit_clks = 16'd3;
        q_n = 4;
        q_mark[0] = 1; q_units[0] = 6;
        q_mark[1] = 1; q_units[1] = 0;
        q_mark[2] = 0; q_units[2] = 2;
        q_mark[3] = 1; q_units[3] = 5;
        play();

        // R6: a lone zero-length command never raises busy.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mark = 1'b1; cmd_units = 16'd0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!busy && !ir_out && !done, "R6 zero count ignored", {busy, ir_out, done}, 0);
            @(posedge clk);
            @(negedge clk);
        end

        // R9 full queue back-pressure, R2 total length and R7 done position.
        cfg_unit_clks = 16'd50; cfg_sub_clks = 12'd1; cfg_duty = 2'd0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_mark = i[0]; cmd_units = 16'd10;
            @(posedge clk);
        end
        @(negedge clk);
        check(cmd_ready == 1'b0, "R9 ready low when full", cmd_ready, 0);
        cmd_units = 16'd7;
        @(posedge clk);
        @(negedge clk);
        check(cmd_ready == 1'b0, "R9 still full", cmd_ready, 0);
        cmd_valid = 1'b0;
        begin
            int cnt;
            cnt = 1;
            while (!done && cnt < 5000) begin
                @(posedge clk);
                @(negedge clk);
                cnt++;
            end
            check(cnt == 2497, "R2 R7 done after queued length", cnt, 2497);
        end
        @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !ir_out && cmd_ready, "R9 offer while full not taken",
              {busy, done, ir_out, cmd_ready}, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule